// File: doc/BRIEF.md
# Byte Load/Store Memory Unit

This unit carries out byte loads and byte stores against a memory that can only move whole 32-bit words and has no byte enables. A command brings a base value, a signed 16-bit displacement, a store-data value, a destination register index, the current program counter and a load/store flag. The unit forms the effective address, sends the word-aligned address to memory, and uses the two low address bits to pick one of four byte lanes, with lane 0 in the least significant byte.

A load reads the word, extracts the chosen byte and returns it zero-extended, together with the destination index and the next program counter. A store reads the word, puts the low byte of the store data into the chosen lane, and writes the merged word back to the same address. The unit is busy from the moment it accepts a command until the last memory acknowledge. It ignores any command offered while it is busy.

Memory handshake: `mem_req_o` stays high with a stable address until `mem_ack_i` arrives. On a read, `mem_rdata_i` is valid in the cycle of the acknowledge.

Top module: `byte_mem_unit`

## Requirements
- R1: The effective address is `base_i` plus `disp_i` sign-extended to 32 bits. `mem_addr_o` carries that address with bits 1:0 forced to zero, and it is held stable while a request waits for its acknowledge.
- R2: A load returns the byte of the read word chosen by effective-address bits 1:0: 0 gives bits 7:0, 1 gives bits 15:8, 2 gives bits 23:16 and 3 gives bits 31:24.
- R3: A load result carries the chosen byte in bits 7:0, and bits 31:8 of `ld_data_o` are zero.
- R4: A store issues a read (`mem_we_o`=0) and then, after that read is acknowledged, a write (`mem_we_o`=1) to the same word address.
- R5: The stored word equals the word that was read, with only the selected lane replaced by `sdata_i[7:0]`. The other three bytes and `sdata_i[31:8]` have no effect on the result.
- R6: With every completion pulse, `next_pc_o` equals the `pc_i` of that command plus 4.
- R7: A load completes with `ld_valid_o` high for exactly one cycle, together with `ld_rd_o` equal to the command's `rd_idx_i`. `st_done_o` stays low.
- R8: A store completes with `st_done_o` high for exactly one cycle. `ld_valid_o` stays low, so there is no register write.
- R9: `busy_o` is high from the cycle after acceptance until the final acknowledge has been taken, and every memory request falls inside that window. A `cmd_valid_i` seen while `busy_o` is high is ignored.
- R10: After reset the unit is idle: `busy_o`, `mem_req_o`, `ld_valid_o` and `st_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered; taken when not busy |
| cmd_store_i | input | 1 | 1 = byte store, 0 = byte load |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| sdata_i | input | 32 | Store data; only bits 7:0 are used |
| rd_idx_i | input | 5 | Destination register index for a load |
| pc_i | input | 32 | Program counter of the command |
| busy_o | output | 1 | A command is in flight |
| ld_valid_o | output | 1 | One-cycle load result strobe |
| ld_data_o | output | 32 | Zero-extended load byte |
| ld_rd_o | output | 5 | Destination index of the load result |
| st_done_o | output | 1 | One-cycle store completion strobe |
| next_pc_o | output | 32 | Program counter plus 4, valid with a strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Merged word for a write |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |

## Verification
The hardest case to reach is a command offered while a store is between its read and its write. The bench holds `cmd_valid_i` high with a conflicting load during the busy window of a store, and the scoreboard then flags any unexpected extra result. Keeping the neighbouring bytes intact is checked by storing into each lane with store data whose upper bits are non-zero. After each store the bench compares the whole memory word, then reads the same byte and the bytes next to it back through loads, using both positive and negative displacements.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bls_state_e;
endpackage

// File: rtl/bls_agen.sv
module bls_agen #(
  parameter int AW    = 32,
  parameter int DISPW = 16,
  parameter int LW    = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [DISPW-1:0] disp_i,
  output logic [AW-1:0]    word_addr_o,
  output logic [LW-1:0]    lane_o
);
  logic [AW-1:0] ea;

  assign ea          = base_i + {{(AW-DISPW){disp_i[DISPW-1]}}, disp_i};
  assign word_addr_o = {ea[AW-1:LW], {LW{1'b0}}};
  assign lane_o      = ea[LW-1:0];
endmodule

// File: rtl/bls_lane.sv
module bls_lane #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] lane_i,
  input  logic [7:0]    byte_i,
  output logic [DW-1:0] ext_o,
  output logic [DW-1:0] merged_o
);
  localparam int NL = DW / 8;

  logic [7:0] lanes [NL];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lanes[g]          = word_i[8*g +: 8];
    assign merged_o[8*g +: 8] = (lane_i == LW'(g)) ? byte_i : word_i[8*g +: 8];
  end

  assign ext_o = {{(DW-8){1'b0}}, lanes[lane_i]};
endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_store_i,
  input  logic mem_ack_i,
  output logic accept_o,
  output logic ld_fin_o,
  output logic wr_cap_o,
  output logic st_fin_o,
  output logic busy_o,
  output logic mem_req_o,
  output logic mem_we_o
);
  bls_state_e state_q, state_d;
  logic       store_q;

  assign accept_o  = (state_q == ST_IDLE) && cmd_valid_i;
  assign ld_fin_o  = (state_q == ST_READ) && mem_ack_i && !store_q;
  assign wr_cap_o  = (state_q == ST_READ) && mem_ack_i && store_q;
  assign st_fin_o  = (state_q == ST_WRITE) && mem_ack_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign mem_req_o = busy_o;
  assign mem_we_o  = (state_q == ST_WRITE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid_i) state_d = ST_READ;
      ST_READ:  if (mem_ack_i)   state_d = store_q ? ST_WRITE : ST_IDLE;
      ST_WRITE: if (mem_ack_i)   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) store_q <= cmd_store_i;
    end
  end
endmodule

// File: rtl/byte_mem_unit.sv
module byte_mem_unit #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DISPW = 16,
  parameter int RIW   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_store_i,
  input  logic [AW-1:0]    base_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [DW-1:0]    sdata_i,
  input  logic [RIW-1:0]   rd_idx_i,
  input  logic [AW-1:0]    pc_i,
  output logic             busy_o,
  output logic             ld_valid_o,
  output logic [DW-1:0]    ld_data_o,
  output logic [RIW-1:0]   ld_rd_o,
  output logic             st_done_o,
  output logic [AW-1:0]    next_pc_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i
);
  localparam int LW   = $clog2(DW / 8);
  localparam int PC_STEP = 4;

  logic            accept, ld_fin, wr_cap, st_fin;
  logic [AW-1:0]   word_addr;
  logic [LW-1:0]   lane;
  logic [DW-1:0]   ext_byte, merged;

  logic [AW-1:0]   addr_q, npc_q;
  logic [LW-1:0]   lane_q;
  logic [7:0]      sbyte_q;
  logic [RIW-1:0]  rd_q;
  logic [DW-1:0]   wdata_q, ld_data_q;
  logic            ld_valid_q, st_done_q;

  bls_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_store_i (cmd_store_i),
    .mem_ack_i   (mem_ack_i),
    .accept_o    (accept),
    .ld_fin_o    (ld_fin),
    .wr_cap_o    (wr_cap),
    .st_fin_o    (st_fin),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o)
  );

  bls_agen #(.AW(AW), .DISPW(DISPW), .LW(LW)) u_agen (
    .base_i      (base_i),
    .disp_i      (disp_i),
    .word_addr_o (word_addr),
    .lane_o      (lane)
  );

  // steering uses the lane latched at accept, not the live command
  bls_lane #(.DW(DW), .LW(LW)) u_lane (
    .word_i   (mem_rdata_i),
    .lane_i   (lane_q),
    .byte_i   (sbyte_q),
    .ext_o    (ext_byte),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      npc_q      <= '0;
      lane_q     <= '0;
      sbyte_q    <= '0;
      rd_q       <= '0;
      wdata_q    <= '0;
      ld_data_q  <= '0;
      ld_valid_q <= 1'b0;
      st_done_q  <= 1'b0;
    end else begin
      ld_valid_q <= ld_fin;
      st_done_q  <= st_fin;
      if (accept) begin
        addr_q  <= word_addr;
        lane_q  <= lane;
        sbyte_q <= sdata_i[7:0];
        rd_q    <= rd_idx_i;
        npc_q   <= pc_i + AW'(PC_STEP);
      end
      if (wr_cap) wdata_q   <= merged;
      if (ld_fin) ld_data_q <= ext_byte;
    end
  end

  assign ld_valid_o  = ld_valid_q;
  assign ld_data_o   = ld_data_q;
  assign ld_rd_o     = rd_q;
  assign st_done_o   = st_done_q;
  assign next_pc_o   = npc_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          ld_valid_o,
  input logic [DW-1:0] ld_data_o,
  input logic          st_done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i
);
  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o));

  a_r3_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> ld_data_o[DW-1:8] == '0);

  a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !$past(mem_req_o && mem_we_o))
      |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

  a_r4_same_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (!mem_req_o || $stable(mem_addr_o)));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |=> !ld_valid_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |=> !st_done_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_valid_o, st_done_o}));

  a_r9_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind byte_mem_unit bls_checker #(.DW(DW), .AW(AW)) u_bls_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .ld_valid_o (ld_valid_o),
  .ld_data_o  (ld_data_o),
  .st_done_o  (st_done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/tb_byte_mem_unit.sv
`timescale 1ns/1ps
module tb_byte_mem_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_store = 1'b0;
  logic [31:0] base = '0, sdata = '0, pc = '0;
  logic [15:0] disp = '0;
  logic [4:0]  rd = '0;
  logic        busy, ld_valid, st_done, mem_req, mem_we;
  logic [31:0] ld_data, next_pc, mem_addr, mem_wdata;
  logic [4:0]  ld_rd;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit          st;
    logic [31:0] addr, data, npc, word;
    logic [4:0]  rd;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];

  always #2.5 clk = ~clk;

  byte_mem_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_store_i(cmd_store),
    .base_i(base), .disp_i(disp), .sdata_i(sdata), .rd_idx_i(rd), .pc_i(pc),
    .busy_o(busy), .ld_valid_o(ld_valid), .ld_data_o(ld_data), .ld_rd_o(ld_rd),
    .st_done_o(st_done), .next_pc_o(next_pc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] pattern(int i);
    return (32'h0102_0304 * (i + 1)) ^ 32'hA5C3_1E70;
  endfunction

  // word memory: acknowledges one cycle after a request, write commits at that edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= pattern(i);
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  task automatic issue(bit st, logic [31:0] b, logic [15:0] d, logic [31:0] sd,
                       logic [4:0] r, logic [31:0] p);
    exp_t e;
    logic [31:0] ea, w;
    int idx, ln;
    ea  = b + {{16{d[15]}}, d};
    idx = int'(ea[7:2]);
    ln  = int'(ea[1:0]);
    e.st = st; e.addr = {ea[31:2], 2'b00}; e.npc = p + 32'd4; e.rd = r;
    e.data = '0; e.word = '0;
    if (st) begin
      w = ref_mem[idx];
      w[8*ln +: 8] = sd[7:0];
      ref_mem[idx] = w;
      e.word = w;
    end else begin
      e.data = {24'h0, ref_mem[idx][8*ln +: 8]};
    end
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_store = st; base = b; disp = d; sdata = sd; rd = r; pc = p;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && exp_q.size() > 0) begin
        check(mem_addr == exp_q[0].addr, "R1", "word address", mem_addr, exp_q[0].addr);
        if (mem_we)
          check(exp_q[0].st, "R4", "write only for store", 32'(mem_we), 32'(exp_q[0].st));
      end
      if (mem_req && exp_q.size() == 0)
        check(1'b0, "R9", "request with nothing pending", 32'(mem_req), 32'd0);
      if (ld_valid || st_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected completion", {30'd0, ld_valid, st_done}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(next_pc == e.npc, "R6", "next pc", next_pc, e.npc);
          if (e.st) begin
            check(st_done && !ld_valid, "R8", "store strobes", {30'd0, ld_valid, st_done}, 32'd1);
            check(mem[e.addr[7:2]] == e.word, "R5", "merged word", mem[e.addr[7:2]], e.word);
          end else begin
            check(ld_valid && !st_done, "R7", "load strobes", {30'd0, ld_valid, st_done}, 32'd2);
            check(32'(ld_rd) == 32'(e.rd), "R7", "dest index", 32'(ld_rd), 32'(e.rd));
            check(ld_data == e.data, "R2", "load byte", ld_data, e.data);
            check(ld_data[31:8] == '0, "R3", "zero fill", ld_data, e.data);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = pattern(i);
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !ld_valid && !st_done, "R10", "reset idle",
          {28'd0, busy, mem_req, ld_valid, st_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req, "R10", "idle after reset", {30'd0, busy, mem_req}, 32'd0);

    // R2 R3: loads of all four lanes
    for (int l = 0; l < 4; l++)
      issue(0, 32'h0000_0100, 16'(l), 32'h0, 5'(l + 1), 32'h1000 + 32'(4*l));

    // R1: negative displacement loads
    issue(0, 32'h0000_0040, 16'hFFFD, 32'h0, 5'd9, 32'h2000);
    issue(0, 32'h0000_0010, 16'hFFF0, 32'h0, 5'd10, 32'hFFFF_FFFC);

    // R5: stores into all lanes with dirty upper store bits
    for (int l = 0; l < 4; l++)
      issue(1, 32'h0000_0080, 16'(4 + l), 32'hDEAD_BE00 | 32'(8'h40 + l), 5'd0, 32'h3000);

    // read back stored byte and neighbours
    for (int l = 0; l < 4; l++)
      issue(0, 32'h0000_0084, 16'(l), 32'h0, 5'd20, 32'h3100);

    // R5: single-lane store then same and neighbouring bytes, negative displacement
    issue(1, 32'h0000_00A0, 16'hFFFE, 32'hFFFF_FF5A, 5'd0, 32'h4000);
    issue(0, 32'h0000_009E, 16'h0000, 32'h0, 5'd21, 32'h4004);
    issue(0, 32'h0000_009D, 16'h0000, 32'h0, 5'd22, 32'h4008);
    issue(0, 32'h0000_009F, 16'h0000, 32'h0, 5'd23, 32'h400C);

    // R9: conflicting load held high while a store is in flight
    issue(1, 32'h0000_00C0, 16'h0001, 32'h0000_0077, 5'd0, 32'h5000);
    cmd_valid = 1'b1; cmd_store = 1'b0; base = 32'h0000_0000; disp = 16'h0; rd = 5'd7;
    check(busy, "R9", "busy during store", 32'(busy), 32'd1);
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    issue(0, 32'h0000_00C0, 16'h0001, 32'h0, 5'd11, 32'h5004);

    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!busy && !mem_req, "R9", "idle at end", {30'd0, busy, mem_req}, 32'd0);
    done = 1;
    finish_run();
  end
endmodule